// File: doc/BRIEF.md
# Reset Qualification and Power-On Test Sequencer

This block sits between the chip's active-low reset input and its start-up logic. While reset is held low it counts clock cycles. When reset rises it compares that count with a minimum hold time. The minimum depends on a clock-mode strap: a short limit when the input clock is divided by two, and a long limit when the clock is used undivided. A reset that was too short leaves the block parked and flagged, and only a new full-length reset starts it again.

After a qualified release, the block walks through the power-on tests. It samples a self-test strap during reset and keeps the value seen at release. If the strap is set, the block starts an internal self-test engine and waits for it. It then always starts an external bus confidence test. An active-low failure output is driven low while each test runs. Between the two tests it goes high for a short gap. It returns high for good on a pass, and stays low if a test fails, which halts the block. When the bus test passes, a one-cycle pulse tells the rest of the chip to branch into user initialization.

The two test engines are outside this block. They connect through a start pulse and a done/pass pair each, and the block waits for done for as long as it takes. Pulling reset low aborts any phase at once.

Top module: `init_sequencer`

## Requirements
- R1: While `rstN` is low, `failN` is 1 and `istStart`, `bctStart`, `userInitGo` and `resetTooShort` are all 0.
- R2: With `clkModeStrap` = 1 (divide-by-two clock), a reset held low for at least 32 rising clock edges is accepted. A reset held for 31 edges is rejected.
- R3: With `clkModeStrap` = 0 (undivided clock), a reset held low for at least 10,000 rising edges is accepted. A reset held for 9,999 edges, or for 32 edges, is rejected.
- R4: A rejected reset sets `resetTooShort` to 1 and keeps `failN` at 1. It starts no test and raises no branch pulse, and the block stays in that state until the next accepted reset, which clears the flag.
- R5: `selfTestStrap` is sampled on every rising edge while `rstN` is low, and the last sample before release is kept. A change on the strap after release has no effect on the test sequence.
- R6: With the kept strap at 1, an accepted release produces a one-cycle `istStart` pulse, and `failN` is 0 in that cycle.
- R7: When the internal test reports done with pass, `failN` returns to 1 for at least one cycle. It then goes back to 0, together with a one-cycle `bctStart` pulse.
- R8: When the internal test reports done without pass, `failN` stays 0, no `bctStart` follows, and the block halts.
- R9: With the kept strap at 0, no `istStart` is issued. A one-cycle `bctStart` follows an accepted release, with `failN` at 0.
- R10: When the bus test reports done with pass, `failN` becomes 1 and stays 1, and `userInitGo` pulses for exactly one cycle, exactly once.
- R11: When the bus test reports done without pass, `failN` stays 0 and `userInitGo` is never raised.
- R12: Pulling `rstN` low during any test wait aborts the sequence and applies the R1 output values, and a following accepted reset runs a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low reset; its low time is measured |
| clkModeStrap | input | 1 | 1 = divide-by-two clock mode (short minimum), 0 = undivided (long minimum) |
| selfTestStrap | input | 1 | 1 = run the internal self-test before the bus test |
| istDone | input | 1 | Internal self-test engine finished (one-cycle pulse) |
| istPass | input | 1 | Internal self-test result, valid with `istDone` |
| bctDone | input | 1 | Bus confidence test engine finished (one-cycle pulse) |
| bctPass | input | 1 | Bus confidence test result, valid with `bctDone` |
| failN | output | 1 | Active-low failure indicator |
| istStart | output | 1 | One-cycle start pulse to the internal self-test engine |
| bctStart | output | 1 | One-cycle start pulse to the bus confidence test engine |
| userInitGo | output | 1 | One-cycle pulse: branch to user initialization |
| resetTooShort | output | 1 | Last reset was shorter than the minimum for the selected mode |

## Verification
The bench holds reset for exactly the minimum and for one edge less, in both clock modes. An off-by-one comparison or a swapped mode decode shows up as a wrongly flagged or wrongly accepted start. It watches `failN` for the one-cycle gap between the two tests. A design that drives it from a single "testing" flag would never show that rise. It flips the self-test strap right after release, so a design that reads the live pin instead of the kept value runs the wrong set of tests. It also pulls reset in the middle of both test waits, which exposes a design that keeps its test state or leaves `failN` low through a new reset.

// File: rtl/initseq_pkg.sv
package initseq_pkg;

  // Strobes from the sequencing FSM to the datapath, one set per cycle
  typedef struct packed {
    logic failOn;     // drive the failure indicator active
    logic startIst;   // start internal self-test
    logic startBct;   // start bus confidence test
    logic branchGo;   // branch to user initialization
    logic shortFlag;  // reset was too short
  } ctrlStrobes_t;

  // Facts the datapath reports back to the FSM
  typedef struct packed {
    logic widthOk;     // low-time count met the selected minimum
    logic selfTestEn;  // self-test strap value kept at release
  } dpStatus_t;

  typedef enum logic [3:0] {
    ST_RESET     = 4'd0,
    ST_IST_START = 4'd1,
    ST_IST_WAIT  = 4'd2,
    ST_IST_PASS  = 4'd3,
    ST_BCT_START = 4'd4,
    ST_BCT_WAIT  = 4'd5,
    ST_BRANCH    = 4'd6,
    ST_RUN       = 4'd7,
    ST_HALT      = 4'd8,
    ST_SHORT     = 4'd9
  } seqState_e;

endpackage

// File: rtl/initseq_datapath.sv
module initseq_datapath
  import initseq_pkg::*;
#(
  parameter int MinDiv2 = 32,
  parameter int MinDiv1 = 10000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clkModeStrap,
  input  logic         selfTestStrap,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status,
  output logic         failN,
  output logic         istStart,
  output logic         bctStart,
  output logic         userInitGo,
  output logic         resetTooShort
);

  localparam int LimMax = (MinDiv1 > MinDiv2) ? MinDiv1 : MinDiv2;
  localparam int CntW   = $clog2(LimMax + 1);
  localparam logic [CntW-1:0] CntCap = CntW'(LimMax);
  localparam logic [CntW-1:0] LimDiv2 = CntW'(MinDiv2);
  localparam logic [CntW-1:0] LimDiv1 = CntW'(MinDiv1);

  logic [CntW-1:0] lowCnt;
  logic            modeQ;
  logic            stestQ;
  logic [CntW-1:0] limit;

  // Low-time counter: counts edges while reset is low, saturates, clears once released
  always_ff @(posedge clk) begin
    if (rstN) begin
      lowCnt <= '0;
    end else if (lowCnt != CntCap) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // Straps follow the pins while reset is low and freeze at release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= clkModeStrap;
      stestQ <= selfTestStrap;
    end
  end

  assign limit = modeQ ? LimDiv2 : LimDiv1;

  always_comb begin
    status.widthOk    = (lowCnt >= limit);
    status.selfTestEn = stestQ;
  end

  // Registered pad-side outputs, forced to their reset values by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failN         <= 1'b1;
      istStart      <= 1'b0;
      bctStart      <= 1'b0;
      userInitGo    <= 1'b0;
      resetTooShort <= 1'b0;
    end else begin
      failN         <= !strobes.failOn;
      istStart      <= strobes.startIst;
      bctStart      <= strobes.startBct;
      userInitGo    <= strobes.branchGo;
      resetTooShort <= strobes.shortFlag;
    end
  end

  AST_IST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    istStart |=> !istStart);  // R6
  AST_BCT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    bctStart |=> !bctStart);  // R9
  AST_USER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    userInitGo |=> !userInitGo);  // R10
  AST_USER_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    userInitGo |-> failN);  // R10
  AST_SHORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    resetTooShort |-> (failN && !istStart && !bctStart && !userInitGo));  // R4

endmodule

// File: rtl/initseq_ctrl.sv
module initseq_ctrl
  import initseq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dpStatus_t    status,
  input  logic         istDone,
  input  logic         istPass,
  input  logic         bctDone,
  input  logic         bctPass,
  output ctrlStrobes_t strobes
);

  seqState_e state;
  seqState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      ST_RESET: begin
        if (!status.widthOk)        nextState = ST_SHORT;
        else if (status.selfTestEn) nextState = ST_IST_START;
        else                        nextState = ST_BCT_START;
      end
      ST_IST_START: begin
        strobes.failOn   = 1'b1;
        strobes.startIst = 1'b1;
        nextState        = ST_IST_WAIT;
      end
      ST_IST_WAIT: begin
        strobes.failOn = 1'b1;
        if (istDone) nextState = istPass ? ST_IST_PASS : ST_HALT;
      end
      ST_IST_PASS: begin
        nextState = ST_BCT_START;
      end
      ST_BCT_START: begin
        strobes.failOn   = 1'b1;
        strobes.startBct = 1'b1;
        nextState        = ST_BCT_WAIT;
      end
      ST_BCT_WAIT: begin
        strobes.failOn = 1'b1;
        if (bctDone) nextState = bctPass ? ST_BRANCH : ST_HALT;
      end
      ST_BRANCH: begin
        strobes.branchGo = 1'b1;
        nextState        = ST_RUN;
      end
      ST_RUN: begin
        nextState = ST_RUN;
      end
      ST_HALT: begin
        strobes.failOn = 1'b1;
        nextState      = ST_HALT;
      end
      ST_SHORT: begin
        strobes.shortFlag = 1'b1;
        nextState         = ST_SHORT;
      end
      default: begin
        nextState = ST_RESET;
      end
    endcase
  end

  AST_IST_NEEDS_STRAP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IST_START) |-> status.selfTestEn);  // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT) |=> (state == ST_HALT));  // R8
  AST_BRANCH_FROM_BCT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BRANCH) |-> ($past(state) == ST_BCT_WAIT));  // R10
  AST_SHORT_FROM_RESET: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SHORT) && ($past(state) != ST_SHORT))
      |-> (($past(state) == ST_RESET) && !$past(status.widthOk)));  // R2

endmodule

// File: rtl/init_sequencer.sv
module init_sequencer
  import initseq_pkg::*;
#(
  parameter int MinDiv2 = 32,
  parameter int MinDiv1 = 10000
) (
  input  logic clk,
  input  logic rstN,
  input  logic clkModeStrap,
  input  logic selfTestStrap,
  input  logic istDone,
  input  logic istPass,
  input  logic bctDone,
  input  logic bctPass,
  output logic failN,
  output logic istStart,
  output logic bctStart,
  output logic userInitGo,
  output logic resetTooShort
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  initseq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .status  (status),
    .istDone (istDone),
    .istPass (istPass),
    .bctDone (bctDone),
    .bctPass (bctPass),
    .strobes (strobes)
  );

  initseq_datapath #(
    .MinDiv2 (MinDiv2),
    .MinDiv1 (MinDiv1)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .clkModeStrap  (clkModeStrap),
    .selfTestStrap (selfTestStrap),
    .strobes       (strobes),
    .status        (status),
    .failN         (failN),
    .istStart      (istStart),
    .bctStart      (bctStart),
    .userInitGo    (userInitGo),
    .resetTooShort (resetTooShort)
  );

endmodule

// File: tb/init_sequencer_tb.sv
module init_sequencer_tb;

  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic clkModeStrap = 1'b1;
  logic selfTestStrap = 1'b1;
  logic istDone = 1'b0, istPass = 1'b0, bctDone = 1'b0, bctPass = 1'b0;
  logic failN, istStart, bctStart, userInitGo, resetTooShort;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // observation results of the last window
  int nIst, nBct, nUser, failViol, widthViol;
  bit gapSeen;
  logic lastFailN, lastShort;

  always #(ClkPeriod/2) clk = ~clk;

  init_sequencer u_dut (
    .clk(clk), .rstN(rstN), .clkModeStrap(clkModeStrap), .selfTestStrap(selfTestStrap),
    .istDone(istDone), .istPass(istPass), .bctDone(bctDone), .bctPass(bctPass),
    .failN(failN), .istStart(istStart), .bctStart(bctStart),
    .userInitGo(userInitGo), .resetTooShort(resetTooShort)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WatchdogCycles) begin
      errors++;
      checks++;
      $display("FAIL watchdog R12: actual cycles=%0d expected below %0d", cycles, WatchdogCycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold reset for edgeCount rising edges, check outputs under reset, release,
  // optionally flip the self-test strap right after release
  task automatic doReset(input bit mode, input int edgeCount, input bit strap, input bit flip);
    @(negedge clk);
    clkModeStrap  = mode;
    selfTestStrap = strap;
    istDone = 1'b0;
    bctDone = 1'b0;
    rstN = 1'b0;
    for (int i = 0; i < edgeCount; i++) @(negedge clk);
    chk("R1 failN in reset", int'(failN), 1);
    chk("R1 pulses in reset", int'({istStart, bctStart, userInitGo, resetTooShort}), 0);
    rstN = 1'b1;
    if (flip) selfTestStrap = ~strap;
  endtask

  // Emulate both test engines and record what the outputs do
  task automatic observe(input int cyc, input bit istAns, input bit istOk,
                         input bit bctAns, input bit bctOk);
    int istT = 0;
    int bctT = 0;
    bit gapArm = 0;
    logic pIst = 0, pBct = 0, pUser = 0;
    nIst = 0; nBct = 0; nUser = 0; failViol = 0; widthViol = 0; gapSeen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      istDone = 1'b0;
      bctDone = 1'b0;
      if (gapArm && failN) gapSeen = 1;
      if (istStart) begin
        nIst++;
        if (failN !== 1'b0) failViol++;
        if (pIst) widthViol++;
      end
      if (bctStart) begin
        nBct++;
        gapArm = 0;
        if (failN !== 1'b0) failViol++;
        if (pBct) widthViol++;
      end
      if (userInitGo) begin
        nUser++;
        if (failN !== 1'b1) failViol++;
        if (pUser) widthViol++;
      end
      pIst = istStart; pBct = bctStart; pUser = userInitGo;
      if (istT > 0) begin
        istT--;
        if (istT == 0 && istAns) begin
          istDone = 1'b1; istPass = istOk;
          gapArm = istOk;
        end
      end
      if (bctT > 0) begin
        bctT--;
        if (bctT == 0 && bctAns) begin
          bctDone = 1'b1; bctPass = bctOk;
        end
      end
      if (istStart) istT = 3;
      if (bctStart) bctT = 4;
    end
    lastFailN = failN;
    lastShort = resetTooShort;
  endtask

  task automatic testFullPass();
    doReset(1'b1, 32, 1'b1, 1'b0);
    observe(60, 1, 1, 1, 1);
    chk("R2 32-edge reset accepted", int'(lastShort), 0);
    chk("R6 one istStart", nIst, 1);
    chk("R7 failN gap between tests", int'(gapSeen), 1);
    chk("R7 one bctStart", nBct, 1);
    chk("R10 one userInitGo", nUser, 1);
    chk("R10 failN high at end", int'(lastFailN), 1);
    chk("R6 failN level at pulses", failViol, 0);
    chk("R10 pulse widths", widthViol, 0);
  endtask

  task automatic testShortDiv2();
    doReset(1'b1, 31, 1'b1, 1'b0);
    observe(40, 1, 1, 1, 1);
    chk("R2 31-edge reset rejected", int'(lastShort), 1);
    chk("R4 no test after short", nIst + nBct + nUser, 0);
    chk("R4 failN high when short", int'(lastFailN), 1);
  endtask

  task automatic testUndivided();
    doReset(1'b0, 32, 1'b0, 1'b0);
    observe(10, 1, 1, 1, 1);
    chk("R3 32 edges rejected undivided", int'(lastShort), 1);
    doReset(1'b0, 9999, 1'b0, 1'b0);
    observe(10, 1, 1, 1, 1);
    chk("R3 9999 edges rejected", int'(lastShort), 1);
    chk("R4 no test after short", nIst + nBct + nUser, 0);
    doReset(1'b0, 10000, 1'b0, 1'b0);
    observe(40, 1, 1, 1, 1);
    chk("R3 10000 edges accepted", int'(lastShort), 0);
    chk("R4 flag cleared by full reset", int'(resetTooShort), 0);
    chk("R9 no istStart when strap clear", nIst, 0);
    chk("R9 one bctStart", nBct, 1);
    chk("R9 failN low with bctStart", failViol, 0);
    chk("R10 userInitGo once", nUser, 1);
  endtask

  task automatic testIstFail();
    doReset(1'b1, 40, 1'b1, 1'b0);
    observe(50, 1, 0, 1, 1);
    chk("R8 istStart issued", nIst, 1);
    chk("R8 no bctStart after fail", nBct, 0);
    chk("R8 no userInitGo", nUser, 0);
    chk("R8 failN held low", int'(lastFailN), 0);
    chk("R8 no failN gap", int'(gapSeen), 0);
  endtask

  task automatic testBctFail();
    doReset(1'b1, 40, 1'b1, 1'b0);
    observe(60, 1, 1, 1, 0);
    chk("R11 bctStart issued", nBct, 1);
    chk("R11 no userInitGo", nUser, 0);
    chk("R11 failN held low", int'(lastFailN), 0);
  endtask

  task automatic testStrapLatch();
    doReset(1'b1, 40, 1'b1, 1'b1);
    observe(50, 1, 1, 1, 1);
    chk("R5 strap kept at 1 after flip", nIst, 1);
    chk("R5 full run", nUser, 1);
    doReset(1'b1, 40, 1'b0, 1'b1);
    observe(50, 1, 1, 1, 1);
    chk("R5 strap kept at 0 after flip", nIst, 0);
    chk("R5 bus test only", nBct, 1);
  endtask

  task automatic testAbort();
    doReset(1'b1, 40, 1'b1, 1'b0);
    observe(20, 0, 0, 0, 0);
    chk("R12 stuck in internal wait", int'(failN), 0);
    doReset(1'b1, 40, 1'b0, 1'b0);
    observe(20, 0, 0, 0, 0);
    chk("R12 new run after abort", nBct, 1);
    chk("R12 stuck in bus wait", int'(failN), 0);
    doReset(1'b1, 40, 1'b1, 1'b0);
    observe(60, 1, 1, 1, 1);
    chk("R12 complete run after aborts", nUser, 1);
    chk("R12 internal test rerun", nIst, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testFullPass();
    testShortDiv2();
    testUndivided();
    testIstFail();
    testBctFail();
    testStrapLatch();
    testAbort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule